// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block is the interrupt unit of a small 8-bit control core. It takes a set of level-sensitive request lines from peripherals and pins. Each line has an individual enable, and two global enables, one for user code and one for library macros, also gate the lines. Among the enabled requests that outrank the routine now running, the block picks the one with the lowest index. It accepts that request only in a cycle where the core reports that an instruction has ended and no fuzzy-rule evaluation is busy.

On acceptance the block pulses `take` for one cycle. It reports the source number and the vector address, which is 3 plus 3 times the source index because each vector slot holds three bytes. In the same step it pushes the core's program counter, its flags and the new priority level onto three stacks that move together. A return strobe pops all three stacks. The saved PC and flags come back on `ret_pc` and `ret_flags`, and the preemption threshold drops back to the level of the interrupted routine. An overrun or underrun of the stacks leaves them untouched and raises a one-cycle error pulse.

The control state machine has two states. `S_MAIN` means no routine is active; `S_ISR` means at least one routine is active. Its transitions are:
- T_ENTER: an acceptance in `S_MAIN` moves to `S_ISR`.
- T_NEST: an acceptance in `S_ISR` stays in `S_ISR` and adds one level.
- T_LEAVE_INNER: a return while more than one level is active stays in `S_ISR`.
- T_RESUME: a return from the last active level moves back to `S_MAIN`.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset no routine is active (`active_valid`=0), `take`, `restore`, `stk_ovf` and `stk_unf` are 0, `usr_en` is 0 and `mac_en` is 1.
- R2: `glob_pend` is 1 exactly when some source i has `src_req[i]`=1 and `src_en[i]`=1, and either no routine is active or i < `active_lvl`. A source whose enable bit is 0 is never accepted.
- R3: An acceptance happens only at a rising edge where `instr_done`=1 and `rule_busy`=0. `take`, `take_id` and `vec_addr` show it in the cycle after that edge.
- R4: When several sources are eligible, the lowest index is accepted.
- R5: `vec_addr` equals 3 + 3 × `take_id`.
- R6: `glob_req` = `glob_pend` AND `usr_en` AND `mac_en`, and acceptance requires `glob_req`. `usr_on`/`usr_off` set and clear `usr_en`, and `mac_on`/`mac_off` do the same for `mac_en`. The new value is seen after the edge, and off wins when both strobes of a pair are high.
- R7: Each acceptance saves `cur_pc` and `cur_flags` from its edge. Each valid `reti` pulses `restore` in the next cycle, with the most recently saved values that have not yet been restored on `ret_pc` and `ret_flags`.
- R8: While a routine of level L is active, only sources with index < L can be accepted. After an acceptance, `active_lvl` equals the accepted index.
- R9: After a return, `active_lvl` is the level of the interrupted routine, or `active_valid`=0 if none is left.
- R10: An acceptance attempted with 6 levels active gives no `take`. Instead `stk_ovf` pulses for one cycle and the stacks stay unchanged.
- R11: A `reti` with no active routine pulses `stk_unf` for one cycle and gives no `restore`.
- R12: When `reti` is high at an edge, no acceptance occurs at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_req | input | 10 | Level request per source |
| src_en | input | 10 | Individual enable per source |
| instr_done | input | 1 | Core is at an instruction boundary |
| rule_busy | input | 1 | Fuzzy-rule evaluation in progress |
| usr_on | input | 1 | Set user global enable |
| usr_off | input | 1 | Clear user global enable |
| mac_on | input | 1 | Set macro global enable |
| mac_off | input | 1 | Clear macro global enable |
| cur_pc | input | 13 | Program counter to save |
| cur_flags | input | 4 | Flags to save |
| reti | input | 1 | Return-from-interrupt strobe |
| glob_pend | output | 1 | Eligible enabled request exists |
| glob_req | output | 1 | Gated global request |
| take | output | 1 | Acceptance pulse |
| take_id | output | 4 | Accepted source index |
| vec_addr | output | 13 | Vector address of accepted source |
| restore | output | 1 | Return pulse |
| ret_pc | output | 13 | Restored program counter |
| ret_flags | output | 4 | Restored flags |
| active_valid | output | 1 | A routine is active |
| active_lvl | output | 4 | Level of the innermost active routine |
| usr_en | output | 1 | User global enable |
| mac_en | output | 1 | Macro global enable |
| stk_ovf | output | 1 | Push refused, stack full |
| stk_unf | output | 1 | Pop refused, stack empty |

## Verification
The bench builds the block with its defaults: ten sources, a 13-bit PC, 4-bit flags and stacks 6 deep. Ten sources are enough to nest six strictly descending levels, fill the stacks and then still offer a higher-priority source, which reaches the refused-push case. The shallow depth also keeps the underrun after six returns short. Random traffic with a fixed seed exercises the enables, the boundary and busy gating, and returns that land on the same edge as a request.

// File: rtl/nic_pkg.sv
package nic_pkg;
    typedef enum logic [0:0] {
        S_MAIN = 1'b0,
        S_ISR  = 1'b1
    } nic_state_e;
endpackage

// File: rtl/nic_prio_pick.sv
module nic_prio_pick #(
    parameter int N     = 10,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    input  logic [N-1:0]     ena,
    input  logic             thr_valid,
    input  logic [IDX_W-1:0] thr,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [N-1:0] elig;

    generate
        for (genvar g = 0; g < N; g++) begin : g_elig
            assign elig[g] = req[g] && ena[g] && (!thr_valid || (IDX_W'(g) < thr));
        end
    endgenerate

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/nic_lifo.sv
module nic_lifo #(
    parameter int W     = 8,
    parameter int DEPTH = 6,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     top,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] cnt;

    assign full  = (cnt == CNT_W'(DEPTH));
    assign empty = (cnt == '0);
    assign count = cnt;
    assign top   = empty ? '0 : mem[PTR_W'(cnt - CNT_W'(1))];

    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[PTR_W'(cnt)] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (push && !full) begin
            cnt <= cnt + CNT_W'(1);
        end else if (pop && !empty) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));
    assert_full_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(cnt));
    assert_empty_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (cnt == '0));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int N          = 10,
    parameter int PC_W       = 13,
    parameter int FLAG_W     = 4,
    parameter int DEPTH      = 6,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 3,
    localparam int IDX_W     = (N > 1) ? $clog2(N) : 1,
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      src_req,
    input  logic [N-1:0]      src_en,
    input  logic              instr_done,
    input  logic              rule_busy,
    input  logic              usr_on,
    input  logic              usr_off,
    input  logic              mac_on,
    input  logic              mac_off,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [FLAG_W-1:0] cur_flags,
    input  logic              reti,
    output logic              glob_pend,
    output logic              glob_req,
    output logic              take,
    output logic [IDX_W-1:0]  take_id,
    output logic [PC_W-1:0]   vec_addr,
    output logic              restore,
    output logic [PC_W-1:0]   ret_pc,
    output logic [FLAG_W-1:0] ret_flags,
    output logic              active_valid,
    output logic [IDX_W-1:0]  active_lvl,
    output logic              usr_en,
    output logic              mac_en,
    output logic              stk_ovf,
    output logic              stk_unf
);
    nic_state_e state, nstate;

    logic             pick_hit;
    logic [IDX_W-1:0] pick_idx;
    logic             try_take, do_push, do_pop, ovf_now, unf_now;

    logic [PC_W-1:0]   pc_top;
    logic [FLAG_W-1:0] fl_top;
    logic [IDX_W-1:0]  lv_top;
    logic [CNT_W-1:0]  pc_cnt, fl_cnt, lv_cnt;
    logic pc_full, pc_empty, fl_full, fl_empty, lv_full, lv_empty;

    assign active_valid = (state == S_ISR);
    assign active_lvl   = lv_top;

    nic_prio_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .req       (src_req),
        .ena       (src_en),
        .thr_valid (active_valid),
        .thr       (lv_top),
        .hit       (pick_hit),
        .idx       (pick_idx)
    );

    assign glob_pend = pick_hit;
    assign glob_req  = glob_pend && usr_en && mac_en;
    assign try_take  = glob_req && instr_done && !rule_busy && !reti;
    assign do_push   = try_take && !lv_full;
    assign ovf_now   = try_take && lv_full;
    assign do_pop    = reti && !lv_empty;
    assign unf_now   = reti && lv_empty;

    nic_lifo #(.W(PC_W), .DEPTH(DEPTH)) u_pc_stk (
        .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop), .din(cur_pc),
        .top(pc_top), .count(pc_cnt), .full(pc_full), .empty(pc_empty)
    );
    nic_lifo #(.W(FLAG_W), .DEPTH(DEPTH)) u_fl_stk (
        .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop), .din(cur_flags),
        .top(fl_top), .count(fl_cnt), .full(fl_full), .empty(fl_empty)
    );
    nic_lifo #(.W(IDX_W), .DEPTH(DEPTH)) u_lv_stk (
        .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop), .din(pick_idx),
        .top(lv_top), .count(lv_cnt), .full(lv_full), .empty(lv_empty)
    );

    // Global enable registers: off strobe dominates
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            usr_en <= 1'b0;
            mac_en <= 1'b1;
        end else begin
            if (usr_off)     usr_en <= 1'b0;
            else if (usr_on) usr_en <= 1'b1;
            if (mac_off)     mac_en <= 1'b0;
            else if (mac_on) mac_en <= 1'b1;
        end
    end

    // Next-state logic (transitions T_ENTER, T_NEST, T_LEAVE_INNER, T_RESUME)
    always_comb begin
        nstate = state;
        unique case (state)
            S_MAIN: if (do_push) nstate = S_ISR;
            S_ISR:  if (do_pop && (lv_cnt == CNT_W'(1))) nstate = S_MAIN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_MAIN;
        else        state <= nstate;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take      <= 1'b0;
            take_id   <= '0;
            vec_addr  <= '0;
            restore   <= 1'b0;
            ret_pc    <= '0;
            ret_flags <= '0;
            stk_ovf   <= 1'b0;
            stk_unf   <= 1'b0;
        end else begin
            take    <= do_push;
            restore <= do_pop;
            stk_ovf <= ovf_now;
            stk_unf <= unf_now;
            if (do_push) begin
                take_id  <= pick_idx;
                vec_addr <= PC_W'(VEC_BASE) + PC_W'(VEC_STRIDE) * PC_W'(pick_idx);
            end
            if (do_pop) begin
                ret_pc    <= pc_top;
                ret_flags <= fl_top;
            end
        end
    end

    assert_take_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ($past(instr_done) && !$past(rule_busy)));
    assert_take_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(glob_req));
    assert_vec_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (vec_addr >= PC_W'(VEC_BASE)
                  && vec_addr <= PC_W'(VEC_BASE + VEC_STRIDE * (N - 1))));
    assert_take_sets_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (active_valid && active_lvl == take_id));
    assert_state_tracks_stack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ISR) == !lv_empty);
    assert_stacks_in_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_cnt == lv_cnt) && (fl_cnt == lv_cnt) && (pc_full == fl_full)
        && (pc_empty == fl_empty));
    assert_no_take_on_reti_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && restore));
endmodule

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb_top;
    localparam int N = 10;
    localparam int DEPTH = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] src_req = '0, src_en = '0;
    logic instr_done = 0, rule_busy = 0, usr_on = 0, usr_off = 0, mac_on = 0, mac_off = 0, reti = 0;
    logic [12:0] cur_pc = '0;
    logic [3:0]  cur_flags = '0;
    logic glob_pend, glob_req, take, restore, active_valid, usr_en, mac_en, stk_ovf, stk_unf;
    logic [3:0]  take_id, active_lvl, ret_flags;
    logic [12:0] vec_addr, ret_pc;

    always #4 clk = ~clk;

    nest_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
        .instr_done(instr_done), .rule_busy(rule_busy), .usr_on(usr_on), .usr_off(usr_off),
        .mac_on(mac_on), .mac_off(mac_off), .cur_pc(cur_pc), .cur_flags(cur_flags),
        .reti(reti), .glob_pend(glob_pend), .glob_req(glob_req), .take(take),
        .take_id(take_id), .vec_addr(vec_addr), .restore(restore), .ret_pc(ret_pc),
        .ret_flags(ret_flags), .active_valid(active_valid), .active_lvl(active_lvl),
        .usr_en(usr_en), .mac_en(mac_en), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
    );

    int total = 0, bad = 0;
    bit done_flag = 0;

    // reference model state
    int m_depth = 0;
    int m_pc [DEPTH];
    int m_fl [DEPTH];
    int m_lv [DEPTH];
    bit m_ue = 0, m_me = 1;

    task automatic chk(string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    function automatic int pick(logic [N-1:0] rq, logic [N-1:0] en);
        for (int i = 0; i < N; i++)
            if (rq[i] && en[i] && (m_depth == 0 || i < m_lv[m_depth-1])) return i;
        return -1;
    endfunction

    task automatic cyc(logic [N-1:0] rq, logic [N-1:0] en, bit dn, bit bz,
                       bit uon, bit uoff, bit mon, bit moff, bit rt);
        int p, e_take, e_rest, e_ovf, e_unf, e_id, e_pc, e_fl, pcv, flv;
        bit gp, gr;
        pcv = int'($urandom_range(0, 8191));
        flv = int'($urandom_range(0, 15));
        src_req = rq; src_en = en; instr_done = dn; rule_busy = bz;
        usr_on = uon; usr_off = uoff; mac_on = mon; mac_off = moff; reti = rt;
        cur_pc = 13'(pcv); cur_flags = 4'(flv);
        #1;
        p = pick(rq, en);
        gp = (p >= 0);
        gr = gp && m_ue && m_me;
        chk("R2 glob_pend", int'(glob_pend), int'(gp));
        chk("R6 glob_req", int'(glob_req), int'(gr));
        chk("R8 active_valid", int'(active_valid), int'(m_depth > 0));
        if (m_depth > 0) chk("R9 active_lvl", int'(active_lvl), m_lv[m_depth-1]);
        e_take = 0; e_rest = 0; e_ovf = 0; e_unf = 0; e_id = 0; e_pc = 0; e_fl = 0;
        if (rt) begin
            if (m_depth > 0) begin
                m_depth--; e_rest = 1; e_pc = m_pc[m_depth]; e_fl = m_fl[m_depth];
            end else e_unf = 1;
        end else if (gr && dn && !bz) begin
            if (m_depth < DEPTH) begin
                m_pc[m_depth] = pcv; m_fl[m_depth] = flv; m_lv[m_depth] = p;
                m_depth++; e_take = 1; e_id = p;
            end else e_ovf = 1;
        end
        if (uoff) m_ue = 0; else if (uon) m_ue = 1;
        if (moff) m_me = 0; else if (mon) m_me = 1;
        @(posedge clk); #1;
        chk("R3 R4 R12 take", int'(take), e_take);
        if (e_take) begin
            chk("R4 R8 take_id", int'(take_id), e_id);
            chk("R5 vec_addr", int'(vec_addr), 3 + 3 * e_id);
        end
        chk("R7 R11 restore", int'(restore), e_rest);
        if (e_rest) begin
            chk("R7 ret_pc", int'(ret_pc), e_pc);
            chk("R7 ret_flags", int'(ret_flags), e_fl);
        end
        chk("R10 stk_ovf", int'(stk_ovf), e_ovf);
        chk("R11 stk_unf", int'(stk_unf), e_unf);
        chk("R6 usr_en", int'(usr_en), int'(m_ue));
        chk("R6 mac_en", int'(mac_en), int'(m_me));
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc('0, '0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            total++; bad++;
            $display("FAIL watchdog act=1 exp=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20417));
        repeat (3) @(posedge clk);
        #1;
        // R1: state right after reset
        chk("R1 active_valid", int'(active_valid), 0);
        chk("R1 take", int'(take), 0);
        chk("R1 restore", int'(restore), 0);
        chk("R1 usr_en", int'(usr_en), 0);
        chk("R1 mac_en", int'(mac_en), 1);
        chk("R1 ovf", int'(stk_ovf), 0);
        chk("R1 unf", int'(stk_unf), 0);
        rst_n = 1'b1;
        idle(2);
        // R6: user enable off -> no request; both strobes -> off wins
        cyc(10'h001, 10'h3FF, 1, 0, 0, 0, 0, 0, 0);
        cyc('0, '0, 0, 0, 1, 1, 0, 0, 0);
        cyc('0, '0, 0, 0, 1, 0, 0, 0, 0);
        // R2: masked sources give nothing
        cyc(10'h3FF, 10'h000, 1, 0, 0, 0, 0, 0, 0);
        // R3: busy blocks, then no boundary blocks, then accepted
        cyc(10'h004, 10'h3FF, 1, 1, 0, 0, 0, 0, 0);
        cyc(10'h004, 10'h3FF, 0, 0, 0, 0, 0, 0, 0);
        cyc(10'h004, 10'h3FF, 1, 0, 0, 0, 0, 0, 0);
        // R8: equal and lower levels held off
        cyc(10'h3FC, 10'h3FF, 1, 0, 0, 0, 0, 0, 0);
        // R12: reti wins over a simultaneous eligible request
        cyc(10'h001, 10'h3FF, 1, 0, 0, 0, 0, 0, 1);
        idle(1);
        // R8 R10: nest 9 down to 4, then source 3 overflows
        for (int s = 9; s >= 4; s--) cyc(10'(1) << s, 10'h3FF, 1, 0, 0, 0, 0, 0, 0);
        chk("R10 depth", int'(active_lvl), 4);
        cyc(10'h008, 10'h3FF, 1, 0, 0, 0, 0, 0, 0);
        cyc(10'h3FF, 10'h3FF, 1, 0, 0, 0, 0, 0, 0);
        // R7 R9 R11: unwind in LIFO order, then underflow
        for (int s = 0; s < DEPTH; s++) cyc('0, '0, 0, 0, 0, 0, 0, 0, 1);
        cyc('0, '0, 0, 0, 0, 0, 0, 0, 1);
        // R6: macro enable off blocks, on again allows
        cyc('0, '0, 0, 0, 0, 0, 0, 1, 0);
        cyc(10'h020, 10'h3FF, 1, 0, 0, 0, 0, 0, 0);
        cyc(10'h020, 10'h3FF, 1, 0, 0, 0, 1, 0, 0);
        cyc(10'h020, 10'h3FF, 1, 0, 0, 0, 0, 0, 0);
        cyc('0, '0, 0, 0, 0, 0, 0, 0, 1);
        // Random traffic
        for (int k = 0; k < 4000; k++) begin
            cyc(10'($urandom), 10'($urandom | $urandom),
                ($urandom_range(0, 1) == 1), ($urandom_range(0, 4) == 0),
                ($urandom_range(0, 9) == 0), ($urandom_range(0, 29) == 0),
                ($urandom_range(0, 9) == 0), ($urandom_range(0, 29) == 0),
                ($urandom_range(0, 6) == 0));
        end
        done_flag = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule